// File: doc/BRIEF.md
# Indexed Memory Protection Region Table

This block holds a small table of protection regions that software never addresses directly. A single index register picks one entry, and the start, end and permission registers then read or write only that entry. A region is a run of 32-byte granules. Its start register holds the first granule and its end register holds the last granule, both inclusive. Address bits below the granule are dropped on write and read back as zero.

Software can write an address to the probe register. Every region is then compared with that address in parallel, and the index register is loaded with the number of the single matching entry. When no region matches, or more than one matches, the index register instead carries a flag. A default attribute register gives the permissions for addresses that no enabled region covers.

A combinational access check takes an address, a write flag and a user flag. In the same cycle it grants or denies the access, using the matching region's permission bits, or the default attribute when nothing matches. It always denies when regions overlap at that address.

Top module: `mpu_region_table`

## Requirements
- R1: After reset every entry is disabled, the default attribute and the index register read 0, and every access check is denied.
- R2: `cfg_sel` selects the register: 0 default attribute, 1 index, 2 start, 3 end, 4 permission, 5 probe. A write to start, end or permission changes only the entry named by index bits [3:0]. Reads return that entry's value. Start and end read back with bits [4:0] zero, permission reads back only bits 0,2,3,4,5,7,8,15,16, the default attribute only bits [8:0], and the probe register reads 0.
- R3: Writing the index register stores bits [3:0] and clears both flags. The index register changes only on an index or probe write.
- R4: An address hits an enabled region when its granule lies between the start granule and the end granule, both inclusive. So the last hit address is end+31.
- R5: An entry is enabled only when permission bits 0 (valid), 15 (secure) and 16 (ID) are all set.
- R6: A probe that hits exactly one region loads that region's number into index bits [3:0], with bits 31 and 30 clear.
- R7: A probe that hits no region sets index bit 31, with the index field 0.
- R8: A probe that hits more than one region sets index bit 30, with the index field 0. Bits 31 and 30 are never set together.
- R9: A kernel read needs attribute bit 7 and a kernel write needs attribute bit 8.
- R10: A user read needs attribute bits 5 and 7. A user write needs attribute bits 4 and 8.
- R11: An address hit by no enabled region is judged with the default attribute bits [8:0].
- R12: An address hit by more than one enabled region is always denied.
- R13: After a probe, the start, end and permission registers access the entry the probe found.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Selected register read data (combinational) |
| chk_addr | input | AW | Address of the access under check |
| chk_write | input | 1 | 1 = write access, 0 = read access |
| chk_user | input | 1 | 1 = user mode, 0 = kernel mode |
| chk_grant | output | 1 | Access allowed |

## Verification
The probe and the access check are tried with addresses on both sides of each region edge: the first granule, the last byte of the end granule, and the byte after it. These show whether the end is treated as inclusive at granule level. Addresses that fall in an enabled region, in a region that is only partly enabled, in no region, and in two overlapping regions show apart region attributes, the default attribute and the overlap denial. User and kernel reads and writes are run against attribute sets that each lack one required bit, which shows whether both bits are demanded. A reference model runs next to the design and compares the read data and the grant on every clock.

// File: rtl/mpu_tbl_pkg.sv
package mpu_tbl_pkg;
  localparam int DW      = 32;
  localparam int PERM_W  = 17;
  localparam int ATTR_W  = 9;

  localparam int P_VALID = 0;
  localparam int P_KEXEC = 2;
  localparam int P_UEXEC = 3;
  localparam int P_UWR   = 4;
  localparam int P_URD   = 5;
  localparam int P_KRD   = 7;
  localparam int P_KWR   = 8;
  localparam int P_SEC   = 15;
  localparam int P_SID   = 16;

  localparam logic [PERM_W-1:0] PERM_MASK = 17'h181BD;

  localparam int FLAG_NONE  = 31;
  localparam int FLAG_MULTI = 30;

  typedef enum logic [2:0] {
    SEL_DFLT  = 3'd0,
    SEL_INDEX = 3'd1,
    SEL_START = 3'd2,
    SEL_END   = 3'd3,
    SEL_PERM  = 3'd4,
    SEL_PROBE = 3'd5
  } reg_sel_e;

  function automatic logic perm_ok(input logic [ATTR_W-1:0] a,
                                   input logic wr, input logic usr);
    logic k;
    k = wr ? a[P_KWR] : a[P_KRD];
    if (usr) perm_ok = k & (wr ? a[P_UWR] : a[P_URD]);
    else     perm_ok = k;
  endfunction
endpackage

// File: rtl/mpu_region_entry.sv
module mpu_region_entry
  import mpu_tbl_pkg::*;
#(
  parameter int AW = 32,
  parameter int GB = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_start,
  input  logic                 wr_end,
  input  logic                 wr_perm,
  input  logic [AW-GB-1:0]     wgran,
  input  logic [PERM_W-1:0]    wperm,
  input  logic [AW-GB-1:0]     probe_g,
  input  logic [AW-GB-1:0]     chk_g,
  output logic [AW-GB-1:0]     start_q,
  output logic [AW-GB-1:0]     end_q,
  output logic [PERM_W-1:0]    perm_q,
  output logic                 probe_hit,
  output logic                 chk_hit
);
  localparam int GW = AW - GB;

  logic [GW-1:0]     start_d, end_d;
  logic [PERM_W-1:0] perm_d;
  logic              enabled;

  always_comb begin
    start_d = wgran;
    end_d   = wgran;
    perm_d  = wperm & PERM_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      end_q   <= '0;
      perm_q  <= '0;
    end else begin
      if (wr_start) start_q <= start_d;
      if (wr_end)   end_q   <= end_d;
      if (wr_perm)  perm_q  <= perm_d;
    end
  end

  assign enabled   = perm_q[P_VALID] & perm_q[P_SEC] & perm_q[P_SID];
  assign probe_hit = enabled && (probe_g >= start_q) && (probe_g <= end_q);
  assign chk_hit   = enabled && (chk_g >= start_q) && (chk_g <= end_q);

  // R2: a start write lands in this entry on the next edge
  assert_start_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |=> start_q == $past(wgran));

  // R5: an entry lacking the ID bit never reports a hit
  assert_disabled_nohit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !perm_q[P_SID] |-> !(probe_hit || chk_hit));
endmodule

// File: rtl/mpu_hit_encoder.sv
module mpu_hit_encoder #(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  logic [N-1:0]  hits,
  output logic [IW-1:0] idx,
  output logic          none,
  output logic          multi
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hits[i]) idx = IW'(i);
    end
  end

  assign none  = (hits == '0);
  assign multi = |(hits & (hits - 1'b1));
endmodule

// File: rtl/mpu_region_table.sv
module mpu_region_table
  import mpu_tbl_pkg::*;
#(
  parameter int NREG = 16,
  parameter int AW   = 32,
  parameter int GB   = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  input  logic [AW-1:0] chk_addr,
  input  logic          chk_write,
  input  logic          chk_user,
  output logic          chk_grant
);
  localparam int IW    = (NREG > 1) ? $clog2(NREG) : 1;
  localparam int NSLOT = 1 << IW;
  localparam int GW    = AW - GB;

  reg_sel_e sel;
  assign sel = reg_sel_e'(cfg_sel);

  logic [DW-1:0]     idx_q, idx_d;
  logic [ATTR_W-1:0] dflt_q, dflt_d;
  logic [IW-1:0]     cur;

  logic [GW-1:0]     start_arr [NSLOT];
  logic [GW-1:0]     end_arr   [NSLOT];
  logic [PERM_W-1:0] perm_arr  [NSLOT];
  logic [NREG-1:0]   probe_hits, chk_hits;

  logic [GW-1:0]     wgran, probe_g, chk_g;
  logic              wr_idx, wr_probe, wr_dflt;

  assign cur      = idx_q[IW-1:0];
  assign wgran    = cfg_wdata[AW-1:GB];
  assign probe_g  = cfg_wdata[AW-1:GB];
  assign chk_g    = chk_addr[AW-1:GB];
  assign wr_idx   = cfg_we && (sel == SEL_INDEX);
  assign wr_probe = cfg_we && (sel == SEL_PROBE);
  assign wr_dflt  = cfg_we && (sel == SEL_DFLT);

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    if (g < NREG) begin : g_ent
      logic ws, we_, wp;
      assign ws  = cfg_we && (sel == SEL_START) && (cur == IW'(g));
      assign we_ = cfg_we && (sel == SEL_END)   && (cur == IW'(g));
      assign wp  = cfg_we && (sel == SEL_PERM)  && (cur == IW'(g));
      mpu_region_entry #(.AW(AW), .GB(GB)) i_entry (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_start  (ws),
        .wr_end    (we_),
        .wr_perm   (wp),
        .wgran     (wgran),
        .wperm     (cfg_wdata[PERM_W-1:0]),
        .probe_g   (probe_g),
        .chk_g     (chk_g),
        .start_q   (start_arr[g]),
        .end_q     (end_arr[g]),
        .perm_q    (perm_arr[g]),
        .probe_hit (probe_hits[g]),
        .chk_hit   (chk_hits[g])
      );
    end else begin : g_pad
      assign start_arr[g] = '0;
      assign end_arr[g]   = '0;
      assign perm_arr[g]  = '0;
    end
  end

  logic [IW-1:0] pr_idx, ck_idx;
  logic          pr_none, pr_multi, ck_none, ck_multi;

  mpu_hit_encoder #(.N(NREG), .IW(IW)) i_probe_enc (
    .hits (probe_hits), .idx (pr_idx), .none (pr_none), .multi (pr_multi)
  );

  mpu_hit_encoder #(.N(NREG), .IW(IW)) i_chk_enc (
    .hits (chk_hits), .idx (ck_idx), .none (ck_none), .multi (ck_multi)
  );

  // next state of index and default registers
  always_comb begin
    idx_d  = idx_q;
    dflt_d = dflt_q;
    if (wr_idx) begin
      idx_d = '0;
      idx_d[IW-1:0] = cfg_wdata[IW-1:0];
    end else if (wr_probe) begin
      idx_d = '0;
      idx_d[FLAG_NONE]  = pr_none;
      idx_d[FLAG_MULTI] = pr_multi;
      if (!pr_none && !pr_multi) idx_d[IW-1:0] = pr_idx;
    end
    if (wr_dflt) dflt_d = cfg_wdata[ATTR_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      dflt_q <= '0;
    end else begin
      if (wr_idx || wr_probe) idx_q  <= idx_d;
      if (wr_dflt)            dflt_q <= dflt_d;
    end
  end

  // register read mux
  always_comb begin
    cfg_rdata = '0;
    case (sel)
      SEL_DFLT:  cfg_rdata[ATTR_W-1:0] = dflt_q;
      SEL_INDEX: cfg_rdata = idx_q;
      SEL_START: cfg_rdata[AW-1:GB] = start_arr[cur];
      SEL_END:   cfg_rdata[AW-1:GB] = end_arr[cur];
      SEL_PERM:  cfg_rdata[PERM_W-1:0] = perm_arr[cur];
      default:   cfg_rdata = '0;
    endcase
  end

  // access check
  logic [ATTR_W-1:0] eff_attr;
  always_comb begin
    eff_attr  = ck_none ? dflt_q : perm_arr[ck_idx][ATTR_W-1:0];
    chk_grant = !ck_multi && perm_ok(eff_attr, chk_write, chk_user);
  end

  // R3: index stays put unless index or probe is written
  assert_idx_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_idx || wr_probe) |=> $stable(idx_q));

  // R3: index write clears both flags
  assert_idx_flags_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_idx |=> (idx_q[FLAG_NONE] == 1'b0) && (idx_q[FLAG_MULTI] == 1'b0));

  // R8: the two probe flags are exclusive
  assert_flags_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(idx_q[FLAG_NONE] && idx_q[FLAG_MULTI]));

  // R7: a flagged result carries a zero index field
  assert_flag_idx_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_q[FLAG_NONE] || idx_q[FLAG_MULTI]) |-> (idx_q[IW-1:0] == '0));

  // R12: overlapping hits deny the access
  assert_overlap_deny_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(chk_hits) > 1) |-> !chk_grant);
endmodule

// File: tb/test_mpu_region_table.sv
module test_mpu_region_table;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic [31:0] chk_addr;
  logic        chk_write, chk_user, chk_grant;

  always #(CLK_PERIOD/2) clk = ~clk;

  mpu_region_table i_mpu_region_table (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .chk_addr(chk_addr),
    .chk_write(chk_write), .chk_user(chk_user), .chk_grant(chk_grant)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit live = 0;
  int cycles = 0;
  string cur_req = "R1";

  // reference model state
  int unsigned m_start [16];
  int unsigned m_end   [16];
  int unsigned m_perm  [16];
  int unsigned m_idx, m_dflt;

  localparam int unsigned EN = 32'h18001;
  localparam int unsigned KR = 32'h80, KW = 32'h100, UR = 32'h20, UW = 32'h10;

  function automatic bit m_hit(int r, int unsigned a);
    bit en;
    en = m_perm[r][0] && m_perm[r][15] && m_perm[r][16];
    return en && ((a >> 5) >= (m_start[r] >> 5)) && ((a >> 5) <= (m_end[r] >> 5));
  endfunction

  function automatic int m_count(int unsigned a, output int first);
    int c = 0;
    first = 0;
    for (int r = 15; r >= 0; r--) if (m_hit(r, a)) begin c++; first = r; end
    return c;
  endfunction

  function automatic bit m_grant(int unsigned a, bit w, bit u);
    int f, c;
    int unsigned at;
    c = m_count(a, f);
    if (c > 1) return 0;
    at = (c == 0) ? m_dflt : m_perm[f];
    if (u) return w ? (at[4] && at[8]) : (at[5] && at[7]);
    return w ? at[8] : at[7];
  endfunction

  function automatic int unsigned m_rdata(int s);
    case (s)
      0: return m_dflt;
      1: return m_idx;
      2: return m_start[m_idx & 15];
      3: return m_end[m_idx & 15];
      4: return m_perm[m_idx & 15];
      default: return 0;
    endcase
  endfunction

  task automatic check(string req, int unsigned act, int unsigned exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #3;
    if (live) begin
      check({cur_req, " rdata"}, cfg_rdata, m_rdata(cfg_sel));
      check({cur_req, " grant"}, {31'd0, chk_grant}, {31'd0, m_grant(chk_addr, chk_write, chk_user)});
    end
  end

  task automatic wr(int s, int unsigned d);
    int f, c;
    cfg_we = 1; cfg_sel = 3'(s); cfg_wdata = d;
    @(posedge clk);
    case (s)
      0: m_dflt = d & 32'h1FF;
      1: m_idx = d & 15;
      2: m_start[m_idx & 15] = d & ~32'h1F;
      3: m_end[m_idx & 15] = d & ~32'h1F;
      4: m_perm[m_idx & 15] = d & 32'h181BD;
      5: begin
        c = m_count(d, f);
        m_idx = (c == 0) ? 32'h8000_0000 : (c > 1) ? 32'h4000_0000 : f;
      end
      default: ;
    endcase
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic rd(string req, int s, int unsigned exp);
    cfg_sel = 3'(s);
    #2;
    check(req, cfg_rdata, exp);
    @(negedge clk);
  endtask

  task automatic acc(string req, int unsigned a, bit w, bit u, bit exp);
    chk_addr = a; chk_write = w; chk_user = u;
    #2;
    check(req, {31'd0, chk_grant}, {31'd0, exp});
    @(negedge clk);
  endtask

  task automatic region(int r, int unsigned s, int unsigned e, int unsigned p);
    wr(1, r); wr(2, s); wr(3, e); wr(4, p);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < 16; r++) begin m_start[r] = 0; m_end[r] = 0; m_perm[r] = 0; end
    m_idx = 0; m_dflt = 0;
    rst_n = 0; cfg_we = 0; cfg_sel = 0; cfg_wdata = 0;
    chk_addr = 0; chk_write = 0; chk_user = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    live = 1;

    cur_req = "R1";
    rd("R1 index after reset", 1, 0);
    rd("R1 default after reset", 0, 0);
    rd("R1 entry perm after reset", 4, 0);
    acc("R1 kernel read denied", 32'h1000, 0, 0, 0);

    cur_req = "R2";
    wr(1, 6);
    wr(2, 32'h0000_101F);
    rd("R2 start low bits dropped", 2, 32'h1000);
    wr(4, 32'hFFFF_FFFF);
    rd("R2 perm defined bits only", 4, 32'h181BD);
    wr(4, 0);
    wr(0, 32'hFFFF_FFFF);
    rd("R2 default nine bits", 0, 32'h1FF);
    wr(0, KR);
    rd("R2 probe reads zero", 5, 0);

    cur_req = "R4";
    region(0, 32'h1000, 32'h1FE0, EN | KR | KW | UR);
    region(1, 32'h3000, 32'h3000, EN | KR | KW | UR | UW);
    region(2, 32'h5000, 32'h50E0, 32'h8001 | KR | KW);
    region(4, 32'h7000, 32'h7000, EN | UR);
    wr(1, 0);
    rd("R3 index write readback", 1, 0);
    rd("R2 start of entry 0", 2, 32'h1000);
    rd("R2 end of entry 0", 3, 32'h1FE0);
    acc("R4 last byte of end granule", 32'h1FFF, 1, 0, 1);
    acc("R4 first byte of start", 32'h1000, 1, 0, 1);
    acc("R11 byte past end uses default", 32'h2000, 1, 0, 0);
    acc("R11 default kernel read", 32'h2000, 0, 0, 1);
    acc("R11 default lacks user read", 32'h0FFF, 0, 1, 0);

    cur_req = "R10";
    acc("R10 user read with UR+KR", 32'h1800, 0, 1, 1);
    acc("R10 user write lacks UW", 32'h1800, 1, 1, 0);
    acc("R10 user write UW+KW", 32'h301F, 1, 1, 1);
    acc("R10 user read lacks KR", 32'h7004, 0, 1, 0);
    acc("R9 kernel read lacks KR", 32'h7004, 0, 0, 0);
    acc("R9 kernel write KW", 32'h3000, 1, 0, 1);

    cur_req = "R5";
    acc("R5 entry without ID bit ignored", 32'h5010, 1, 0, 0);
    wr(1, 2); wr(4, EN | KR | KW);
    acc("R5 entry now enabled", 32'h5010, 1, 0, 1);

    cur_req = "R6";
    wr(5, 32'h0000_1004);
    rd("R6 probe single hit", 1, 0);
    wr(5, 32'h0000_3010);
    rd("R6 probe hit entry 1", 1, 1);
    rd("R13 start after probe", 2, 32'h3000);
    wr(2, 32'h3000);
    cur_req = "R7";
    wr(5, 32'h0000_9000);
    rd("R7 probe no hit", 1, 32'h8000_0000);
    wr(5, 32'h0000_2000);
    rd("R7 probe past end", 1, 32'h8000_0000);
    wr(1, 3);
    rd("R3 index write clears flag", 1, 3);

    cur_req = "R12";
    wr(2, 32'h1800); wr(3, 32'h1800); wr(4, EN | KR);
    wr(5, 32'h0000_1810);
    rd("R8 probe multi hit", 1, 32'h4000_0000);
    acc("R12 overlap denies kernel read", 32'h1810, 0, 0, 0);
    acc("R12 outside overlap still allowed", 32'h1820, 0, 0, 1);

    cur_req = "R3";
    cfg_sel = 1;
    wr(2, 32'h4000);
    rd("R3 index unchanged by other writes", 1, 32'h4000_0000);

    done = 1;
    live = 0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule